// File: doc/BRIEF.md
# Wide-Write Trace History Recorder

The recorder keeps a history of wide trace records for a debug monitor. On each clock where the capture strobe is high and recording is armed, one 128-bit record goes into a 1024-entry memory in a single cycle, at the entry selected by an internal write index. A slow 8-bit host reads the history back one byte at a time through a separate read port. The read port uses a byte address in which the upper bits select the entry and the low four bits select the byte within it.

Recording runs in one of two modes, chosen when the host loads the control bits. In one-shot mode the memory is filled once. After the last entry is written, recording stops and the block clears its own enable bit. In ring mode the index wraps from the last entry back to entry 0, and recording continues for as long as the block stays enabled. The current write index and a full flag are visible at the ports. After a wrap, the host uses them to find the oldest record.

Top module: `trace_hist_rec`

## Requirements
- R1: When `cap_i` is high and the enable is set, the whole `rec_i` record is written in that clock edge into the entry at `wr_idx_o`, and `wr_idx_o` advances by one.
- R2: While the enable is clear, `cap_i` writes nothing to memory and `wr_idx_o` does not move.
- R3: Read address bits [13:4] select the entry and bits [3:0] select byte k. `rdata_o` returns bits [8k+7:8k] of that entry's record, registered, in the clock after the address is presented.
- R4: When the same entry is written and read in one cycle, the read returns the contents from before the write.
- R5: In one-shot mode, writing entry 1023 clears the enable, sets `full_o` and returns the index to 0. Later strobes change neither the memory nor the index.
- R6: In ring mode the index wraps from 1023 to 0, `full_o` is set, the enable stays set and recording continues, overwriting the oldest entries.
- R7: A pulse on `ctl_wr_i` loads the enable from `en_i` and the mode from `cont_i` (1 = ring). A load that turns the enable on from off in one-shot mode resets the index to 0 and clears `full_o`. Any other load keeps the index and the flag.
- R8: After reset the index is 0, `full_o` is 0, the enable is 0, the mode is one-shot and `rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_wr_i | input | 1 | Load pulse for the enable and mode bits |
| en_i | input | 1 | Enable value to load |
| cont_i | input | 1 | Mode value to load (1 = ring, 0 = one-shot) |
| cap_i | input | 1 | Capture strobe |
| rec_i | input | 128 | Trace record to store |
| raddr_i | input | 14 | Byte read address {entry, byte} |
| rdata_o | output | 8 | Registered read byte |
| wr_idx_o | output | 10 | Current write index |
| full_o | output | 1 | Set once the last entry has been written |
| en_o | output | 1 | Current enable state |

## Verification
Strobes are applied in four patterns: with the block disarmed, with idle gaps between them, back-to-back through a complete one-shot fill, and back-to-back across a ring wrap. Comparing these separates gating by the enable from plain index stepping, and stopping at the end of the memory from wrapping. Each record has a distinct value in every byte lane, so byte reads at low, middle and top offsets show up any swap of lanes or entries. A write and a read aimed at the same entry in one cycle confirm that the old data is returned. Control loads are applied both as a rising enable and as a repeated enable, which shows whether the index restart depends on the mode.

// File: rtl/trace_hist_pkg.sv
package trace_hist_pkg;
  localparam int unsigned DEF_ENTRIES   = 1024;
  localparam int unsigned DEF_REC_BYTES = 16;

  typedef enum logic {
    MODE_ONESHOT = 1'b0,
    MODE_RING    = 1'b1
  } cap_mode_e;
endpackage

// File: rtl/trace_store.sv
module trace_store #(
  parameter int unsigned ENTRIES   = 1024,
  parameter int unsigned REC_BYTES = 16,
  localparam int unsigned REC_W    = REC_BYTES * 8,
  localparam int unsigned IDX_W    = $clog2(ENTRIES),
  localparam int unsigned BSEL_W   = $clog2(REC_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [REC_W-1:0]  wdata_i,
  input  logic [IDX_W-1:0]  ridx_i,
  input  logic [BSEL_W-1:0] rbsel_i,
  output logic [7:0]        rdata_o
);
  logic [REC_W-1:0] mem_q [ENTRIES];
  logic [REC_W-1:0] rword;
  logic [7:0]       lane [REC_BYTES];
  logic [7:0]       rdata_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[widx_i] <= wdata_i;
  end

  assign rword = mem_q[ridx_i];

  for (genvar g = 0; g < REC_BYTES; g++) begin : g_lane
    assign lane[g] = rword[g*8 +: 8];
  end

  // nonblocking read of the array: same-entry write is seen next cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= lane[rbsel_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/trace_wctl.sv
module trace_wctl
  import trace_hist_pkg::*;
#(
  parameter int unsigned ENTRIES = 1024,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_wr_i,
  input  logic             en_i,
  input  logic             cont_i,
  input  logic             cap_i,
  output logic             we_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             full_o,
  output logic             en_o,
  output cap_mode_e        mode_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic             en_q, full_q;
  cap_mode_e        mode_q;
  logic [IDX_W-1:0] idx_q;
  logic             fire, at_last, restart;

  assign fire    = cap_i & en_q;
  assign at_last = (idx_q == LAST);
  assign restart = ctl_wr_i & en_i & ~en_q & ~cont_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      full_q <= 1'b0;
      mode_q <= MODE_ONESHOT;
      idx_q  <= '0;
    end else begin
      if (fire) begin
        idx_q <= at_last ? '0 : idx_q + 1'b1;
        if (at_last) begin
          full_q <= 1'b1;
          if (mode_q == MODE_ONESHOT) en_q <= 1'b0;
        end
      end
      // host load overrides capture side effects
      if (ctl_wr_i) begin
        en_q   <= en_i;
        mode_q <= cont_i ? MODE_RING : MODE_ONESHOT;
        if (restart) begin
          idx_q  <= '0;
          full_q <= 1'b0;
        end
      end
    end
  end

  assign we_o   = fire;
  assign idx_o  = idx_q;
  assign full_o = full_q;
  assign en_o   = en_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/trace_hist_rec.sv
module trace_hist_rec
  import trace_hist_pkg::*;
#(
  parameter int unsigned ENTRIES   = DEF_ENTRIES,
  parameter int unsigned REC_BYTES = DEF_REC_BYTES,
  localparam int unsigned REC_W    = REC_BYTES * 8,
  localparam int unsigned IDX_W    = $clog2(ENTRIES),
  localparam int unsigned BSEL_W   = $clog2(REC_BYTES),
  localparam int unsigned ADDR_W   = IDX_W + BSEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_wr_i,
  input  logic              en_i,
  input  logic              cont_i,
  input  logic              cap_i,
  input  logic [REC_W-1:0]  rec_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [7:0]        rdata_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic              full_o,
  output logic              en_o
);
  logic             we;
  logic [IDX_W-1:0] widx;
  cap_mode_e        mode;

  trace_wctl #(.ENTRIES(ENTRIES)) u_wctl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ctl_wr_i (ctl_wr_i),
    .en_i     (en_i),
    .cont_i   (cont_i),
    .cap_i    (cap_i),
    .we_o     (we),
    .idx_o    (widx),
    .full_o   (full_o),
    .en_o     (en_o),
    .mode_o   (mode)
  );

  trace_store #(.ENTRIES(ENTRIES), .REC_BYTES(REC_BYTES)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .widx_i  (widx),
    .wdata_i (rec_i),
    .ridx_i  (raddr_i[ADDR_W-1:BSEL_W]),
    .rbsel_i (raddr_i[BSEL_W-1:0]),
    .rdata_o (rdata_o)
  );

  assign wr_idx_o = widx;
endmodule

// File: rtl/trace_hist_chk.sv
module trace_hist_chk #(
  parameter int unsigned ENTRIES = 1024,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ctl_wr_i,
  input logic             en_i,
  input logic             cont_i,
  input logic             cap_i,
  input logic             ring_i,
  input logic [IDX_W-1:0] wr_idx_o,
  input logic             full_o,
  input logic             en_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && en_o && !ctl_wr_i && wr_idx_o != LAST)
      |=> (wr_idx_o == IDX_W'($past(wr_idx_o) + 1'b1))); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_o && !ctl_wr_i) |=> ($stable(wr_idx_o) && !en_o)); // R2

  AST_ONESHOT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && en_o && !ring_i && !ctl_wr_i && wr_idx_o == LAST)
      |=> (!en_o && full_o && wr_idx_o == '0)); // R5

  AST_RING_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && en_o && ring_i && !ctl_wr_i && wr_idx_o == LAST)
      |=> (en_o && full_o && wr_idx_o == '0)); // R6

  AST_ARM_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr_i && en_i && !cont_i && !en_o)
      |=> (en_o && !full_o && wr_idx_o == '0)); // R7

  AST_FULL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !ctl_wr_i) |=> full_o); // R6
endmodule

bind trace_hist_rec trace_hist_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ctl_wr_i (ctl_wr_i),
  .en_i     (en_i),
  .cont_i   (cont_i),
  .cap_i    (cap_i),
  .ring_i   (mode == trace_hist_pkg::MODE_RING),
  .wr_idx_o (wr_idx_o),
  .full_o   (full_o),
  .en_o     (en_o)
);

// File: tb/sim_trace_hist_rec.sv
module sim_trace_hist_rec;
  localparam int N = 1024;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ctl_wr = 1'b0, en_in = 1'b0, cont_in = 1'b0, cap = 1'b0;
  logic [127:0] rec = '0;
  logic [13:0]  raddr = '0;
  logic [7:0]   rdata;
  logic [9:0]   wr_idx;
  logic         full, en_out;

  int vecs = 0, errs = 0;

  trace_hist_rec u0 (
    .clk_i(clk), .rst_ni(rst_n), .ctl_wr_i(ctl_wr), .en_i(en_in), .cont_i(cont_in),
    .cap_i(cap), .rec_i(rec), .raddr_i(raddr), .rdata_o(rdata),
    .wr_idx_o(wr_idx), .full_o(full), .en_o(en_out)
  );

  always #2 clk = ~clk;

  // reference model built from the requirements
  logic [127:0] model [N];
  int  m_idx = 0;
  bit  m_full = 0, m_en = 0, m_cont = 0;

  typedef struct { logic [7:0] exp; string tag; } rd_item_t;
  rd_item_t sb_q[$];
  logic rd_vld = 1'b0, rd_vld_d = 1'b0;

  function automatic logic [127:0] mk(int n, int s);
    logic [127:0] r;
    for (int b = 0; b < 16; b++) r[b*8 +: 8] = 8'(n * 7 + b * 29 + s * 53 + (n >> 8));
    return r;
  endfunction

  // monitor
  always @(posedge clk) rd_vld_d <= rd_vld;
  always @(negedge clk) begin
    if (rd_vld_d) begin
      rd_item_t it;
      it = sb_q.pop_front();
      vecs++;
      if (rdata !== it.exp) begin
        errs++;
        $display("FAIL %s rdata act=%02h exp=%02h", it.tag, rdata, it.exp);
      end
    end
  end

  task automatic chk_state(string tag);
    vecs++;
    if (wr_idx !== 10'(m_idx) || full !== m_full || en_out !== m_en) begin
      errs++;
      $display("FAIL %s idx/full/en act=%0d/%0b/%0b exp=%0d/%0b/%0b",
               tag, wr_idx, full, en_out, m_idx, m_full, m_en);
    end
  endtask

  function automatic void model_cap(logic [127:0] r);
    if (m_en) begin
      model[m_idx] = r;
      if (m_idx == N - 1) begin
        m_idx = 0; m_full = 1;
        if (!m_cont) m_en = 0;
      end else m_idx++;
    end
  endfunction

  // all tasks start and end at a negedge
  task automatic cap_burst(int n, int seed, bit gap);
    for (int i = 0; i < n; i++) begin
      rec = mk(m_idx + i, seed); cap = 1'b1;
      @(negedge clk);
      model_cap(rec);
      if (gap) begin cap = 1'b0; @(negedge clk); end
    end
    cap = 1'b0;
  endtask

  task automatic rd(int e, int k, string tag);
    raddr = {10'(e), 4'(k)}; rd_vld = 1'b1;
    sb_q.push_back('{model[e][k*8 +: 8], tag});
    @(negedge clk);
    rd_vld = 1'b0;
  endtask

  task automatic ctl(bit e, bit c);
    ctl_wr = 1'b1; en_in = e; cont_in = c;
    @(negedge clk);
    ctl_wr = 1'b0;
    if (e && !m_en && !c) begin m_idx = 0; m_full = 0; end
    m_en = e; m_cont = c;
  endtask

  initial begin
    #800000;
    errs++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    vecs++;
    if (rdata !== 8'h00) begin errs++; $display("FAIL R8 rdata act=%02h exp=00", rdata); end
    chk_state("R8 reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_state("R8 after release");

    cap_burst(4, 1, 0);
    chk_state("R2 strobes while disarmed");

    ctl(1, 0);
    chk_state("R7 arm one-shot");
    cap_burst(5, 2, 1);
    chk_state("R1 gapped captures");
    for (int e = 0; e < 5; e++) begin
      rd(e, 0, "R3 byte0");
      rd(e, 5, "R3 byte5");
      rd(e, 15, "R1 byte15");
    end
    for (int k = 0; k < 16; k++) rd(2, k, "R3 lane sweep");

    cap_burst(N - 6, 3, 0);
    chk_state("R1 one before end");
    cap_burst(1, 3, 0);
    chk_state("R5 one-shot stop");
    rd(1023, 0, "R5 last entry");
    rd(1023, 15, "R5 last entry top");

    cap_burst(3, 4, 0);
    chk_state("R5 strobes after stop");
    rd(0, 7, "R2 entry0 untouched");
    rd(1, 9, "R2 entry1 untouched");

    ctl(1, 0);
    chk_state("R7 re-arm restart");

    // same-entry write and read
    rec = mk(777, 5); cap = 1'b1;
    raddr = {10'd0, 4'd3}; rd_vld = 1'b1;
    sb_q.push_back('{model[0][3*8 +: 8], "R4 old data"});
    @(negedge clk);
    model_cap(rec);
    cap = 1'b0; rd_vld = 1'b0;
    rd(0, 3, "R4 new data next");
    chk_state("R1 after overlap");

    cap_burst(2, 6, 0);
    ctl(0, 0);
    chk_state("R7 disarm keeps index");
    ctl(1, 1);
    chk_state("R7 ring arm keeps index");

    cap_burst(N + 2, 7, 0);
    chk_state("R6 ring wrap");
    rd(3, 4, "R6 overwritten");
    rd(4, 12, "R6 overwritten");
    rd(1023, 1, "R6 tail");
    rd(5, 0, "R6 oldest");
    ctl(1, 1);
    chk_state("R7 repeat enable no restart");

    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule